// File: doc/BRIEF.md
# Accumulator Operate, Shift and Skip Unit

This unit carries out the register-only instruction groups of a 16-bit accumulator machine. It takes a complete instruction word together with the current accumulator (AC), link bit, front-panel switch word and six external status flags. It returns the new AC and link. It also returns three requests for the surrounding sequencer: skip the next instruction, halt, and start the display processor. Program counter handling, memory traffic and the status sources all stay with the sequencer.

The sequencer pulses `start` with its inputs valid. For most words the unit answers one clock later with a single-cycle `done`. Rotates and arithmetic shifts advance one bit position per clock, so a shift of two or three positions keeps `busy` high until its last step. All outputs are registered. They stay constant between `done` pulses, so the sequencer may sample them whenever convenient after `done`.

Top module: `accop_unit`

## Requirements
- R1: A word with bits 14:6 all zero is a micro-operation word. It completes one clock after `start`. `halt` is 1 exactly when bit 15 of that word is 0.
- R2: In a micro-operation word the first step clears AC (bit 0) and clears the link (bit 3). The second step then complements AC (bit 1) and complements the link (bit 4), so clear followed by complement yields all ones.
- R3: The third micro-operation step runs after the first two. Bit 2 adds one to AC and toggles the link when AC wraps to zero. Bit 5 then ORs `dsw` into AC, after the increment.
- R4: A word whose bits 15:9 are 0000011 is a shift word. Bits 1:0 give a count of 0 to 3. Bit 5 selects an arithmetic shift (1) or a rotate (0). Bit 4 selects the right direction (1) or the left direction (0). Bit 6 sets `disp_start`.
- R5: A rotate moves the 17-bit pair {link, AC} by one place per count. Left rotation puts AC bit 15 into the link and the old link into AC bit 0. Right rotation puts AC bit 0 into the link and the old link into AC bit 15.
- R6: An arithmetic shift keeps AC bit 15 and never alters the link. Left shift drops bit 14 and fills bit 0 with zero. Right shift copies bit 15 into bit 14.
- R7: A shift word raises `done` max(count,1) clocks after `start`. A count of 0 returns AC and link unchanged.
- R8: A word whose bits 14:9 are 000010 is a skip word. Its select bits test the following conditions. Bit 0 tests AC equal to zero. Bit 1 tests AC bit 15 clear. Bit 2 tests link clear. Bits 3 to 8 test `ext_flags[0]` to `ext_flags[5]` respectively. AC and link pass through unchanged.
- R9: The results of all selected skip conditions are ORed together. Bit 15 then inverts the result, so a skip word with no select bits set and bit 15 set requests a skip.
- R10: A `start` that arrives while `busy` is high is ignored. It neither changes the running result nor produces an extra `done`.
- R11: Any other word completes one clock after `start`. It returns AC and link unchanged and raises none of `skip`, `halt` or `disp_start`.
- R12: Reset clears every output. The outputs change only on a clock that raises `done`. At most one of `skip`, `halt` and `disp_start` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the word and operands on this edge when idle |
| instr | input | 16 | Instruction word |
| ac_in | input | DW | Current accumulator |
| link_in | input | 1 | Current link bit |
| dsw | input | DW | Front-panel switch word |
| ext_flags | input | 6 | Display running, key ready, serial in ready, serial out done, frame sync, tape ready |
| ac_out | output | DW | Resulting accumulator |
| link_out | output | 1 | Resulting link bit |
| skip | output | 1 | Skip-next request |
| halt | output | 1 | Halt request |
| disp_start | output | 1 | Display start request |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A multi-step shift is in progress |

## Verification
The unit samples `start` on a rising edge. Micro-operation words, skip words, unrecognised words and shift words with a count of 0 or 1 raise `done` on the next edge. Shift words with a count of 2 or 3 raise `done` two or three edges after the start edge. The bench drives inputs on falling edges and counts falling edges until `done` appears. Each check compares that count with max(count,1) and compares the registered outputs in the same half-cycle. Sweeps cover every micro-operation pattern, every shift word low field and every skip selection with both polarities.

// File: rtl/accop_pkg.sv
package accop_pkg;
  localparam int IW   = 16;   // instruction word width
  localparam int NEXT = 6;    // external status flags
  localparam int NSEL = 3 + NEXT;
  localparam int CW   = 2;    // shift count width

  typedef enum logic [1:0] {K_OTHER, K_MICRO, K_SHIFT, K_SKIP} kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [CW-1:0]   count;
    logic            arith;
    logic            right;
    logic            disp;
  } dec_t;
endpackage

// File: rtl/accop_decode.sv
module accop_decode
  import accop_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          dec
);
  logic is_micro, is_shift, is_skip;

  assign is_micro = (instr[14:6] == 9'd0);
  assign is_shift = (instr[15:9] == 7'b0000011);
  assign is_skip  = (instr[14:9] == 6'b000010);

  always_comb begin
    dec.count = instr[CW-1:0];
    dec.arith = instr[5];
    dec.right = instr[4];
    dec.disp  = instr[6];
    if (is_micro)      dec.kind = K_MICRO;
    else if (is_shift) dec.kind = K_SHIFT;
    else if (is_skip)  dec.kind = K_SKIP;
    else               dec.kind = K_OTHER;
  end
endmodule

// File: rtl/accop_micro.sv
module accop_micro #(
  parameter int DW = 16
) (
  input  logic [5:0]    ops,
  input  logic [DW-1:0] ac_i,
  input  logic          link_i,
  input  logic [DW-1:0] dsw,
  output logic [DW-1:0] ac_o,
  output logic          link_o
);
  logic [DW-1:0] a1, a2, a3, inc;
  logic          l1, l2, l3;

  // first step: clears
  assign a1  = ops[0] ? '0 : ac_i;
  assign l1  = ops[3] ? 1'b0 : link_i;
  // second step: complements
  assign a2  = ops[1] ? ~a1 : a1;
  assign l2  = ops[4] ? ~l1 : l1;
  // third step: increment, then switch merge
  assign inc = a2 + {{(DW-1){1'b0}}, 1'b1};
  assign a3  = ops[2] ? inc : a2;
  assign l3  = (ops[2] && (inc == '0)) ? ~l2 : l2;
  assign ac_o   = ops[5] ? (a3 | dsw) : a3;
  assign link_o = l3;
endmodule

// File: rtl/accop_step.sv
module accop_step #(
  parameter int DW = 16
) (
  input  logic          arith,
  input  logic          right,
  input  logic [DW-1:0] ac_i,
  input  logic          link_i,
  output logic [DW-1:0] ac_o,
  output logic          link_o
);
  always_comb begin
    case ({arith, right})
      2'b00: begin
        link_o = ac_i[DW-1];
        ac_o   = {ac_i[DW-2:0], link_i};
      end
      2'b01: begin
        link_o = ac_i[0];
        ac_o   = {link_i, ac_i[DW-1:1]};
      end
      2'b10: begin
        link_o = link_i;
        ac_o   = {ac_i[DW-1], ac_i[DW-3:0], 1'b0};
      end
      default: begin
        link_o = link_i;
        ac_o   = {ac_i[DW-1], ac_i[DW-1:1]};
      end
    endcase
  end
endmodule

// File: rtl/accop_skip.sv
module accop_skip
  import accop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [NSEL-1:0] sel,
  input  logic            negate,
  input  logic [DW-1:0]   ac_i,
  input  logic            link_i,
  input  logic [NEXT-1:0] ext,
  output logic            skip_o
);
  logic [NSEL-1:0] cond;

  assign cond[0] = (ac_i == '0);
  assign cond[1] = ~ac_i[DW-1];
  assign cond[2] = ~link_i;

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    assign cond[3+g] = ext[g];
  end

  assign skip_o = (|(sel & cond)) ^ negate;
endmodule

// File: rtl/accop_unit.sv
module accop_unit
  import accop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IW-1:0]   instr,
  input  logic [DW-1:0]   ac_in,
  input  logic            link_in,
  input  logic [DW-1:0]   dsw,
  input  logic [NEXT-1:0] ext_flags,
  output logic [DW-1:0]   ac_out,
  output logic            link_out,
  output logic            skip,
  output logic            halt,
  output logic            disp_start,
  output logic            done,
  output logic            busy
);
  localparam logic [CW-1:0] CNT_ZERO = '0;
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  dec_t          dec;
  logic [DW-1:0] mic_ac, sin_ac, swk_ac;
  logic          mic_l, sin_l, swk_l, skip_w;

  logic [DW-1:0] wk_ac_q;
  logic          wk_l_q;
  logic [CW-1:0] remain_q;
  logic          arith_q, right_q, pend_disp_q;
  logic [DW-1:0] ac_q;
  logic          l_q, skip_q, halt_q, disp_q, done_q, busy_q;
  logic          accept;

  accop_decode u_dec (.instr(instr), .dec(dec));

  accop_micro #(.DW(DW)) u_micro (
    .ops(instr[5:0]), .ac_i(ac_in), .link_i(link_in), .dsw(dsw),
    .ac_o(mic_ac), .link_o(mic_l)
  );

  accop_step #(.DW(DW)) u_step_in (
    .arith(dec.arith), .right(dec.right), .ac_i(ac_in), .link_i(link_in),
    .ac_o(sin_ac), .link_o(sin_l)
  );

  accop_step #(.DW(DW)) u_step_wk (
    .arith(arith_q), .right(right_q), .ac_i(wk_ac_q), .link_i(wk_l_q),
    .ac_o(swk_ac), .link_o(swk_l)
  );

  accop_skip #(.DW(DW)) u_skip (
    .sel(instr[NSEL-1:0]), .negate(instr[IW-1]), .ac_i(ac_in),
    .link_i(link_in), .ext(ext_flags), .skip_o(skip_w)
  );

  assign accept = start && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_ac_q     <= '0;
      wk_l_q      <= 1'b0;
      remain_q    <= '0;
      arith_q     <= 1'b0;
      right_q     <= 1'b0;
      pend_disp_q <= 1'b0;
      ac_q        <= '0;
      l_q         <= 1'b0;
      skip_q      <= 1'b0;
      halt_q      <= 1'b0;
      disp_q      <= 1'b0;
      done_q      <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        case (dec.kind)
          K_MICRO: begin
            ac_q   <= mic_ac;
            l_q    <= mic_l;
            skip_q <= 1'b0;
            halt_q <= ~instr[IW-1];
            disp_q <= 1'b0;
            done_q <= 1'b1;
          end
          K_SKIP: begin
            ac_q   <= ac_in;
            l_q    <= link_in;
            skip_q <= skip_w;
            halt_q <= 1'b0;
            disp_q <= 1'b0;
            done_q <= 1'b1;
          end
          K_SHIFT: begin
            arith_q     <= dec.arith;
            right_q     <= dec.right;
            pend_disp_q <= dec.disp;
            if (dec.count == CNT_ZERO) begin
              ac_q   <= ac_in;
              l_q    <= link_in;
              skip_q <= 1'b0;
              halt_q <= 1'b0;
              disp_q <= dec.disp;
              done_q <= 1'b1;
            end else if (dec.count == CNT_ONE) begin
              ac_q   <= sin_ac;
              l_q    <= sin_l;
              skip_q <= 1'b0;
              halt_q <= 1'b0;
              disp_q <= dec.disp;
              done_q <= 1'b1;
            end else begin
              wk_ac_q  <= sin_ac;
              wk_l_q   <= sin_l;
              remain_q <= dec.count - CNT_ONE;
              busy_q   <= 1'b1;
            end
          end
          default: begin
            ac_q   <= ac_in;
            l_q    <= link_in;
            skip_q <= 1'b0;
            halt_q <= 1'b0;
            disp_q <= 1'b0;
            done_q <= 1'b1;
          end
        endcase
      end else if (busy_q) begin
        wk_ac_q  <= swk_ac;
        wk_l_q   <= swk_l;
        remain_q <= remain_q - CNT_ONE;
        if (remain_q == CNT_ONE) begin
          ac_q   <= swk_ac;
          l_q    <= swk_l;
          skip_q <= 1'b0;
          halt_q <= 1'b0;
          disp_q <= pend_disp_q;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign ac_out     = ac_q;
  assign link_out   = l_q;
  assign skip       = skip_q;
  assign halt       = halt_q;
  assign disp_start = disp_q;
  assign done       = done_q;
  assign busy       = busy_q;
endmodule

// File: rtl/accop_chk.sv
module accop_chk
  import accop_pkg::*;
#(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [IW-1:0]   instr,
  input logic [DW-1:0]   ac_out,
  input logic            link_out,
  input logic            skip,
  input logic            halt,
  input logic            disp_start,
  input logic            done,
  input logic            busy
);
  // R12: outputs move only on a done edge
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(ac_out) && $stable(link_out) && $stable(skip)
               && $stable(halt) && $stable(disp_start)));

  // R12: request flags never coexist
  assert_flags_excl_R12: assert property (@(posedge clk) disable iff (rst)
    $countones({skip, halt, disp_start}) <= 1);

  // R10: completion always leaves the unit idle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: a multi-step run only begins from a start request
  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R1: micro-operation words finish next cycle with halt from bit 15
  assert_micro_halt_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (instr[14:6] == 9'd0)) |=> (done && (halt == !$past(instr[15]))));

  // R9: skip word with empty selection yields the negate bit
  assert_empty_skip_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (instr[14:9] == 6'b000010) && (instr[8:0] == 9'd0))
      |=> (done && (skip == $past(instr[15]))));
endmodule

bind accop_unit accop_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .instr(instr),
  .ac_out(ac_out), .link_out(link_out), .skip(skip), .halt(halt),
  .disp_start(disp_start), .done(done), .busy(busy)
);

// File: tb/tb_accop_unit.sv
module tb_accop_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] ac_in = '0;
  logic        link_in = 1'b0;
  logic [15:0] dsw = '0;
  logic [5:0]  ext = '0;
  logic [15:0] ac_out;
  logic        link_out, skip, halt, disp_start, done, busy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  accop_unit #(.DW(16)) dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .ac_in(ac_in),
    .link_in(link_in), .dsw(dsw), .ext_flags(ext), .ac_out(ac_out),
    .link_out(link_out), .skip(skip), .halt(halt), .disp_start(disp_start),
    .done(done), .busy(busy)
  );

  task automatic op(input logic [15:0] w, input logic [15:0] a, input logic l,
                    input logic [15:0] d, input logic [5:0] e, input int lat,
                    input logic [15:0] eac, input logic el, input logic es,
                    input logic eh, input logic edp, input string tag);
    int k;
    @(negedge clk);
    instr = w; ac_in = a; link_in = l; dsw = d; ext = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 8) begin
      @(negedge clk);
      k++;
    end
    n_run++;
    if (k != lat || ac_out != eac || link_out != el || skip != es ||
        halt != eh || disp_start != edp) begin
      n_fail++;
      $display("FAIL %s w=%h lat=%0d exp %0d ac=%h exp %h l=%b exp %b s=%b exp %b h=%b exp %b d=%b exp %b",
               tag, w, k, lat, ac_out, eac, link_out, el, skip, es, halt, eh, disp_start, edp);
    end
  endtask

  // micro-operation model (R2, R3)
  task automatic model_micro(input logic [5:0] m, input logic [15:0] a0, input logic l0,
                             input logic [15:0] d, output logic [15:0] a, output logic l);
    a = a0; l = l0;
    if (m[0]) a = 16'h0000;
    if (m[3]) l = 1'b0;
    if (m[1]) a = ~a;
    if (m[4]) l = ~l;
    if (m[2]) begin
      a = a + 16'd1;
      if (a == 16'h0000) l = ~l;
    end
    if (m[5]) a = a | d;
  endtask

  // shift/rotate model (R5, R6)
  task automatic model_shift(input logic [6:0] f, input logic [15:0] a0, input logic l0,
                             output logic [15:0] a, output logic l);
    logic [16:0] v;
    a = a0; l = l0;
    for (int i = 0; i < int'(f[1:0]); i++) begin
      if (!f[5]) begin
        v = {l, a};
        v = f[4] ? {v[0], v[16:1]} : {v[15:0], v[16]};
        l = v[16]; a = v[15:0];
      end else if (f[4]) begin
        a = (a & 16'h8000) | (a >> 1);
      end else begin
        a = (a & 16'h8000) | ((a << 1) & 16'h7fff);
      end
    end
  endtask

  // skip model (R8, R9)
  function automatic logic model_skip(input logic [8:0] s, input logic neg,
                                      input logic [15:0] a, input logic l, input logic [5:0] e);
    logic hit;
    hit = 1'b0;
    if (s[0] && a == 16'h0000) hit = 1'b1;
    if (s[1] && a < 16'h8000) hit = 1'b1;
    if (s[2] && l == 1'b0) hit = 1'b1;
    for (int i = 0; i < 6; i++)
      if (s[3+i] && e[i]) hit = 1'b1;
    return hit ^ neg;
  endfunction

  initial begin
    #(5 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ea, acs[4], dws[2];
    logic        el;
    int          k;
    acs[0] = 16'h0000; acs[1] = 16'hFFFF; acs[2] = 16'h8001; acs[3] = 16'h5A3C;
    dws[0] = 16'h0000; dws[1] = 16'h0F81;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_run++;  // R12 reset state
    if (ac_out != 16'h0 || link_out || skip || halt || disp_start || done || busy) begin
      n_fail++;
      $display("FAIL R12 reset ac=%h exp 0000 flags=%b%b%b%b%b%b exp 000000",
               ac_out, link_out, skip, halt, disp_start, done, busy);
    end

    // R1 R2 R3: all micro patterns, both halt polarities
    for (int m = 0; m < 64; m++)
      for (int h = 0; h < 2; h++)
        for (int ai = 0; ai < 4; ai++)
          for (int li = 0; li < 2; li++) begin
            model_micro(6'(m), acs[ai], li[0], dws[ai % 2], ea, el);
            op({h[0], 9'd0, 6'(m)}, acs[ai], li[0], dws[ai % 2], 6'd0, 1,
               ea, el, 1'b0, ~h[0], 1'b0, "R1 R2 R3 micro");
          end

    // R4 R5 R6 R7: every shift-word low field
    for (int f = 0; f < 128; f++)
      for (int ai = 0; ai < 4; ai++)
        for (int li = 0; li < 2; li++) begin
          model_shift(7'(f), acs[ai], li[0], ea, el);
          op(16'h0600 | 16'(f), acs[ai], li[0], 16'hFFFF, 6'h3F,
             (f % 4 == 0) ? 1 : (f % 4), ea, el, 1'b0, 1'b0, f[6],
             "R4 R5 R6 R7 shift");
        end

    // R8 R9: every selection, both polarities, several operand sets
    for (int s = 0; s < 512; s++)
      for (int n = 0; n < 2; n++)
        for (int c = 0; c < 4; c++) begin
          logic [15:0] a;
          logic        l;
          logic [5:0]  e;
          a = (c == 0) ? 16'h0000 : (c == 1) ? 16'h8000 : (c == 2) ? 16'h0001 : 16'hFFFF;
          l = c[0];
          e = (c == 0) ? 6'b000000 : (c == 1) ? 6'b010101 : (c == 2) ? 6'b101010 : 6'b111111;
          op({n[0], 6'b000010, 9'(s)}, a, l, 16'h1234, e, 1, a, l,
             model_skip(9'(s), n[0], a, l, e), 1'b0, 1'b0, "R8 R9 skip");
        end

    // R11: unrecognised words pass operands through
    op(16'h1234, 16'hBEEF, 1'b1, 16'hFFFF, 6'h3F, 1, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0, "R11 other");
    op(16'h4000, 16'h0000, 1'b0, 16'hFFFF, 6'h3F, 1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R11 other");
    op(16'hFFFF, 16'h7777, 1'b1, 16'h0000, 6'h00, 1, 16'h7777, 1'b1, 1'b0, 1'b0, 1'b0, "R11 other");
    op(16'h0200, 16'h1111, 1'b0, 16'h0000, 6'h00, 1, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0, "R11 other");

    // R10: start during a 3-step rotate is ignored
    @(negedge clk);
    instr = 16'h0643; ac_in = 16'h8001; link_in = 1'b0; start = 1'b1;
    @(negedge clk);
    instr = 16'h0001; ac_in = 16'hFFFF; link_in = 1'b1;  // busy now, must be ignored
    k = 1;
    while (!done && k < 8) begin
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    n_run++;
    if (k != 3 || ac_out != 16'h000A || link_out != 1'b0 || disp_start != 1'b1) begin
      n_fail++;
      $display("FAIL R10 busy start lat=%0d exp 3 ac=%h exp 000a l=%b exp 0 d=%b exp 1",
               k, ac_out, link_out, disp_start);
    end
    @(negedge clk);
    n_run++;
    if (done || ac_out != 16'h000A) begin
      n_fail++;
      $display("FAIL R10 extra done=%b exp 0 ac=%h exp 000a", done, ac_out);
    end

    // R12: outputs hold while inputs move without start
    op(16'h0004, 16'hFFFF, 1'b0, 16'h0000, 6'd0, 1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, "R12 setup");
    @(negedge clk);
    instr = 16'h0001; ac_in = 16'h1234; link_in = 1'b0; dsw = 16'hFFFF;
    repeat (3) @(negedge clk);
    n_run++;
    if (ac_out != 16'h0000 || link_out != 1'b1 || halt != 1'b1 || done) begin
      n_fail++;
      $display("FAIL R12 hold ac=%h exp 0000 l=%b exp 1 h=%b exp 1 done=%b exp 0",
               ac_out, link_out, halt, done);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule